// File: doc/BRIEF.md
# Serial Combination Lock Controller

This controller guards a door with a short secret code that the user keys in one bit at a time. The user sets a single key switch, then presses an enter button. Each press samples the switch and compares it with the next bit of a stored code. Code bit 0 is checked first. When the final press of the sequence arrives, the controller stops in one of two terminal states. One terminal state opens the lock. The other raises an error indication.

A wrong bit does not stop the sequence early. The controller still accepts every remaining press, so the user cannot tell from the lock's behaviour which position was wrong. The code sits in a register. It can be rewritten only while the lock is idle at the beginning of a sequence.

A user-level clear input returns the controller to that starting point from any state. There is no data stream at this block's edge. Enter, clear and load are plain level control pins, the outcome pins are plain status levels, and no valid/ready handshake or back-pressure applies.

Top module: `serial_lock`

## Requirements
- R1: After `rst_n` is released, `unlock` and `error` are both 0, the controller is at the start of a sequence, and the stored code equals `RESET_CODE` (default 3'b101).
- R2: A press is a 0-to-1 change of `enter` between two clock edges. Holding `enter` high for several cycles counts as exactly one press.
- R3: The k-th press of a sequence (k = 1..NBITS) compares `key_bit` with stored code bit k-1, so code bit 0 is compared first. `key_bit` is sampled on the clock edge that registers the press.
- R4: If all NBITS presses match, `unlock` goes to 1 in the cycle after the clock edge of the final press. It stays 1 until a clear.
- R5: If any press mismatches, `error` goes to 1 in the cycle after the clock edge of the final press, and not earlier. This holds even when the first bit was wrong.
- R6: `unlock` and `error` are never 1 together. Both are 0 while a sequence is incomplete.
- R7: `clear` high on a clock edge returns the controller to the start of a sequence from any state, with both outputs 0 in the next cycle. `clear` takes priority over a press on the same edge.
- R8: `load` high on a clock edge writes `load_data` into the stored code only when no press of the current sequence has yet been registered. At any other time `load` is ignored and the old code stays in force.
- R9: Presses while `unlock` or `error` is 1 are ignored. The output stays unchanged until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| clear | input | 1 | User clear: restart the sequence |
| enter | input | 1 | Enter button level; its rising change is a press |
| key_bit | input | 1 | Key switch value sampled on a press |
| load | input | 1 | Write strobe for the stored code |
| load_data | input | NBITS | New code value; bit 0 is checked first |
| unlock | output | 1 | Correct full sequence entered |
| error | output | 1 | Full sequence entered with at least one wrong bit |

## Verification
The hardest case to reach from the ports is an early mismatch whose failure must stay hidden. In that case the outputs must stay low through the later presses, and the error must appear only after the final one. The stimulus therefore directs sequences that are wrong only in the first bit, mixed with random code and key pairs.

A second hard case is a code write attempted after the first press has been registered. The bench issues such writes mid-sequence and in the terminal states. It then shows that the old code still governs the outcome. Enter is also held high for several cycles, to show that one long press advances the sequence only once.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_OPEN    = 2'd1,
    PH_FAIL    = 2'd2
  } lock_phase_e;
endpackage

// File: rtl/press_edge.sv
module press_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign pulse = level & ~level_q;

  // R2
  single_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/combo_reg.sv
module combo_reg #(
  parameter int NBITS = 3,
  parameter logic [NBITS-1:0] RESET_CODE = 3'b101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             allow,
  input  logic [NBITS-1:0] wdata,
  output logic [NBITS-1:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            code <= RESET_CODE;
    else if (wr && allow)  code <= wdata;
  end

  // R8
  load_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !allow) |=> $stable(code));
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
#(
  parameter int NBITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             press,
  input  logic             key_bit,
  input  logic [NBITS-1:0] code,
  output logic             unlock,
  output logic             error,
  output logic             at_start
);
  localparam int STEP_W = $clog2(NBITS + 1);

  lock_phase_e       phase;
  logic [STEP_W-1:0] step;
  logic              bad;
  logic              want;
  logic              mis;
  logic              last;

  always_comb begin
    want = 1'b0;
    for (int i = 0; i < NBITS; i++) begin
      if (step == STEP_W'(i)) want = code[i];
    end
  end

  assign mis  = key_bit ^ want;
  assign last = (step == STEP_W'(NBITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_COLLECT;
      step  <= '0;
      bad   <= 1'b0;
    end else if (clear) begin
      phase <= PH_COLLECT;
      step  <= '0;
      bad   <= 1'b0;
    end else if (phase == PH_COLLECT && press) begin
      if (last) begin
        phase <= (bad | mis) ? PH_FAIL : PH_OPEN;
        step  <= '0;
        bad   <= 1'b0;
      end else begin
        step <= step + 1'b1;
        bad  <= bad | mis;
      end
    end
  end

  assign unlock   = (phase == PH_OPEN);
  assign error    = (phase == PH_FAIL);
  assign at_start = (phase == PH_COLLECT) && (step == '0);

  // R6
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlock && error));
  // R5
  late_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> ($past(press) && $past(last) && !$past(clear)));
  // R7
  clear_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!unlock && !error && at_start));
  // R9
  final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((unlock || error) && !clear) |=> ($stable(unlock) && $stable(error)));
endmodule

// File: rtl/serial_lock.sv
module serial_lock #(
  parameter int NBITS = 3,
  parameter logic [NBITS-1:0] RESET_CODE = 3'b101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enter,
  input  logic             key_bit,
  input  logic             load,
  input  logic [NBITS-1:0] load_data,
  output logic             unlock,
  output logic             error
);
  logic             press;
  logic             at_start;
  logic [NBITS-1:0] code;

  press_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (enter),
    .pulse (press)
  );

  combo_reg #(.NBITS(NBITS), .RESET_CODE(RESET_CODE)) u_code (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (load),
    .allow (at_start),
    .wdata (load_data),
    .code  (code)
  );

  lock_fsm #(.NBITS(NBITS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .press    (press),
    .key_bit  (key_bit),
    .code     (code),
    .unlock   (unlock),
    .error    (error),
    .at_start (at_start)
  );
endmodule

// File: tb/sim_serial_lock.sv
`timescale 1ns/1ps
module sim_serial_lock;
  localparam int NBITS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic enter = 1'b0;
  logic key_bit = 1'b0;
  logic load = 1'b0;
  logic [NBITS-1:0] load_data = '0;
  logic unlock, error;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [NBITS-1:0] model_code;

  always #2.5 clk = ~clk;

  serial_lock #(.NBITS(NBITS)) u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .enter(enter),
    .key_bit(key_bit), .load(load), .load_data(load_data),
    .unlock(unlock), .error(error)
  );

  function automatic logic [1:0] expect_out(logic [NBITS-1:0] c, logic [NBITS-1:0] k);
    return (c == k) ? 2'b10 : 2'b01;
  endfunction

  task automatic check(string req, logic [1:0] exp);
    checks++;
    if ({unlock, error} !== exp) begin
      failures++;
      $display("FAIL %s: {unlock,error} actual=%b expected=%b", req, {unlock, error}, exp);
    end
  endtask

  task automatic press(logic b, int hold, int gap);
    @(negedge clk);
    key_bit = b;
    enter = 1'b1;
    for (int i = 1; i < hold; i++) @(negedge clk);
    @(negedge clk);
    enter = 1'b0;
    key_bit = ~b;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    check("R7", 2'b00);
  endtask

  task automatic do_load(logic [NBITS-1:0] d);
    @(negedge clk); load = 1'b1; load_data = d;
    @(negedge clk); load = 1'b0; load_data = ~d;
  endtask

  // enters a full sequence; checks each partial step and the result
  task automatic sequence_run(logic [NBITS-1:0] k, string req, int maxhold);
    for (int i = 0; i < NBITS; i++) begin
      press(k[i], 1 + int'($urandom % maxhold), int'($urandom % 2));
      if (i < NBITS - 1) check("R6", 2'b00);
    end
    check(req, expect_out(model_code, k));
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_code = 3'b101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'b00);

    // R1: reset code 101 opens
    sequence_run(3'b101, "R1", 1);
    // R9: presses in final state ignored
    press(1'b0, 1, 0); check("R9", 2'b10);
    do_clear();

    // R3: bit 0 is compared first: reversed pattern 101 vs 011 load
    do_load(3'b011); model_code = 3'b011;
    sequence_run(3'b110, "R3", 1);
    press(1'b1, 2, 0); check("R9", 2'b01);
    do_clear();
    sequence_run(3'b011, "R4", 1);
    do_clear();

    // R5: only first bit wrong, outputs low until final press
    sequence_run(3'b010, "R5", 1);
    do_clear();

    // R2: long hold counts once
    press(1'b1, 5, 0); check("R2", 2'b00);
    press(1'b1, 1, 0); check("R2", 2'b00);
    press(1'b0, 1, 0); check("R2", expect_out(model_code, 3'b011));
    do_clear();

    // R8: load mid-sequence ignored
    press(1'b1, 1, 0);
    do_load(3'b000);
    press(1'b1, 1, 0);
    press(1'b0, 1, 0); check("R8", 2'b10);
    do_load(3'b111);
    do_clear();
    sequence_run(3'b011, "R8", 1);
    do_clear();

    // R7: clear mid-sequence restarts
    press(1'b0, 1, 0);
    do_clear();
    sequence_run(3'b011, "R7", 1);
    do_clear();

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [NBITS-1:0] k;
      if ($urandom % 2 == 1) begin
        logic [NBITS-1:0] nc;
        nc = NBITS'($urandom);
        do_load(nc);
        model_code = nc;
      end
      k = ($urandom % 3 == 0) ? model_code : NBITS'($urandom);
      sequence_run(k, "R4", 4);
      if ($urandom % 2 == 1) begin
        do_load(~model_code);
        press(1'b1, 1, 0);
        check("R9", expect_out(model_code, k));
      end
      do_clear();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule